// File: doc/BRIEF.md
# Flagless Dual-Clock Line Buffer

This block moves active-video samples from an input pixel clock to an unrelated output pixel clock through a dual-port store. The write side accepts a sample on every input clock where its enable is high. The source raises that enable only for the visible part of a line, so sync and blanking periods cost no storage. The read side delivers one sample per output clock where its enable is high. It does this only after the buffer has reported that it is ready to be read.

The block has no full or empty flags. Underflow is prevented by a single indication raised by the write side once a set number of complete lines has been stored. That indication is carried into the read clock through a chain of flip-flops and then held in the read domain until reset. Overflow is prevented by sizing. The depth covers the lines stored before reading starts plus at least one spare line, so the write pointer cannot lap the read pointer. Both pointers wrap at the depth. Reset is asserted asynchronously and released separately in each clock domain.

Top module: `line_xfer_buf`

## Requirements
- R1: While reset is asserted, and afterwards until the first accepted read, `ready` is 0 and `rd_data` is 0. Reset clears both pointers to location 0.
- R2: `ready` stays 0 until LINE_SAMPLES*READY_LINES samples have been written (512 by default). It rises a few `rd_clk` cycles after that write.
- R3: Once `ready` is 1 it stays 1 until reset is asserted again, whatever the enables do.
- R4: A read request made while `ready` is 0 is ignored. The read pointer and `rd_data` do not change, and the first accepted read returns the first sample written after reset.
- R5: A read is accepted at a `rd_clk` edge where `rd_en` and `ready` are both 1. The sample appears on `rd_data` after that same edge (one cycle of latency). Samples come out in the order they were written, and `rd_data` holds its value while no read is accepted.
- R6: Both pointers wrap from DEPTH-1 to 0 (modulus DEPTH, which must be a power of two). The sample stream stays in order across the wrap.
- R7: A `wr_clk` cycle with `wr_en` low stores nothing and leaves the write pointer unchanged. Blanking gaps therefore leave no holes in the sample stream.
- R8: The write-side indication passes through at least SYNC_STAGES (2 or more) `rd_clk` flip-flops before it reaches `ready`. So `ready` cannot rise within one `rd_clk` edge of the write that reaches the threshold.
- R9: DEPTH is at least (READY_LINES + MARGIN_LINES) * LINE_SAMPLES, with MARGIN_LINES of 1 or more. This is checked when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Global reset, active low, asserted asynchronously |
| wr_clk | input | 1 | Input pixel clock |
| wr_en | input | 1 | High during active video; stores `wr_data` |
| wr_data | input | DATA_W | Sample to store |
| rd_clk | input | 1 | Output pixel clock |
| rd_en | input | 1 | Read request; honoured only while `ready` is 1 |
| rd_data | output | DATA_W | Registered sample, updated one cycle after an accepted read |
| ready | output | 1 | Latched read-domain indication that two lines are stored |

## Verification
The hardest situation to reach is the interval in which the reader already asks for data but the ready indication is still crossing clock domains. The ready indication must then arrive late enough that the first sample is not lost and early enough that the lag is fixed. The stimulus raises `rd_en` 4 µs after writing starts. That is well before two lines with their blanking gap are stored, so the reader spends over a microsecond requesting without effect. The bench also records the first read clock edge after the write that reaches the threshold and checks that `ready` is still low there. The read clock runs slightly slower than the write clock at its peak but faster than the average write rate including blanking. This brings the pointers closer over a long run, and both pointers wrap at least once.

// File: rtl/lxb_pkg.sv
package lxb_pkg;

  // Number of samples that must be stored before the reader may start.
  function automatic int unsigned lxb_ready_mark(input int unsigned lines,
                                                 input int unsigned samples);
    return lines * samples;
  endfunction

  // Next location of a circular pointer with the given modulus.
  function automatic int unsigned lxb_wrap_next(input int unsigned idx,
                                                input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  function automatic bit lxb_is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // Depth must cover the lines held before reading plus spare lines.
  function automatic bit lxb_depth_ok(input int unsigned depth,
                                      input int unsigned lines,
                                      input int unsigned margin,
                                      input int unsigned samples);
    return (margin >= 1) && (depth >= (lines + margin) * samples);
  endfunction

endpackage

// File: rtl/lxb_rst_sync.sv
module lxb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[N-2:0], 1'b1};
  end

  assign rst_n_sync = chain[N-1];
endmodule

// File: rtl/lxb_flag_sync.sv
module lxb_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_in,
  output logic flag_out,
  output logic flag_first
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= flag_in;
        else             chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign flag_first = chain[0];
  assign flag_out   = chain[N-1];
endmodule

// File: rtl/lxb_wr_side.sv
module lxb_wr_side
  import lxb_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int THRESH = 512,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(THRESH + 1)
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_en,
  output logic             wr_fire,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] wr_count,
  output logic             wr_flag
);
  localparam logic [CNT_W-1:0] MARK      = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] MARK_LAST = CNT_W'(THRESH - 1);

  assign wr_fire = wr_en & wr_rst_n;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wr_ptr   <= '0;
      wr_count <= '0;
      wr_flag  <= 1'b0;
    end else if (wr_fire) begin
      wr_ptr <= PTR_W'(lxb_wrap_next(int'(wr_ptr), DEPTH));
      if (wr_count != MARK)      wr_count <= wr_count + CNT_W'(1);
      if (wr_count == MARK_LAST) wr_flag  <= 1'b1;
    end
  end
endmodule

// File: rtl/lxb_rd_side.sv
module lxb_rd_side
  import lxb_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_en,
  input  logic             flag_synced,
  output logic             rd_accept,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             ready
);
  assign rd_accept = rd_en & ready;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      ready  <= 1'b0;
      rd_ptr <= '0;
    end else begin
      ready <= ready | flag_synced;
      if (rd_accept) rd_ptr <= PTR_W'(lxb_wrap_next(int'(rd_ptr), DEPTH));
    end
  end
endmodule

// File: rtl/lxb_ram.sv
module lxb_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rdata <= '0;
    else if (re)   rdata <= mem[raddr];
  end
endmodule

// File: rtl/line_xfer_buf.sv
module line_xfer_buf
  import lxb_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 1024,
  parameter int LINE_SAMPLES = 256,
  parameter int READY_LINES  = 2,
  parameter int MARGIN_LINES = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);
  localparam int THRESH = int'(lxb_ready_mark(READY_LINES, LINE_SAMPLES));
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(THRESH + 1);

  logic             wr_rst_n, rd_rst_n;
  logic             wr_fire, wr_flag;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] wr_count;
  logic             flag_synced, flag_first;
  logic             rd_accept;

  lxb_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .arst_n(rst_n), .rst_n_sync(wr_rst_n));

  lxb_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .arst_n(rst_n), .rst_n_sync(rd_rst_n));

  lxb_wr_side #(.DEPTH(DEPTH), .THRESH(THRESH)) u_wr (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en),
    .wr_fire(wr_fire), .wr_ptr(wr_ptr), .wr_count(wr_count),
    .wr_flag(wr_flag));

  lxb_flag_sync #(.STAGES(SYNC_STAGES)) u_flag_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .flag_in(wr_flag),
    .flag_out(flag_synced), .flag_first(flag_first));

  lxb_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .flag_synced(flag_synced), .rd_accept(rd_accept),
    .rd_ptr(rd_ptr), .ready(ready));

  lxb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .wr_clk(wr_clk), .we(wr_fire), .waddr(wr_ptr), .wdata(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .re(rd_accept),
    .raddr(rd_ptr), .rdata(rd_data));
endmodule

// File: rtl/lxb_checker.sv
module lxb_checker
  import lxb_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 1024,
  parameter int LINE_SAMPLES = 256,
  parameter int READY_LINES  = 2,
  parameter int MARGIN_LINES = 1,
  parameter int THRESH       = 512,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(THRESH + 1)
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_n,
  input logic              rd_rst_n,
  input logic              wr_en,
  input logic              wr_fire,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [CNT_W-1:0]  wr_count,
  input logic              wr_flag,
  input logic              flag_first,
  input logic              flag_synced,
  input logic              rd_accept,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [DATA_W-1:0] rd_data,
  input logic              ready
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  initial begin
    assert_depth_sizing_R9: assert (lxb_is_pow2(DEPTH) &&
        lxb_depth_ok(DEPTH, READY_LINES, MARGIN_LINES, LINE_SAMPLES))
      else $error("depth too small or not a power of two");
  end

  assert_reset_state_R1: assert property (@(posedge rd_clk)
    !rd_rst_n |-> (rd_ptr == '0 && !ready && rd_data == '0));

  assert_flag_at_mark_R2: assert property (@(posedge wr_clk)
    disable iff (!wr_rst_n) $rose(wr_flag) |-> wr_count == CNT_W'(THRESH));

  assert_ready_sticky_R3: assert property (@(posedge rd_clk)
    disable iff (!rd_rst_n) ready |=> ready);

  assert_idle_read_holds_R4: assert property (@(posedge rd_clk)
    disable iff (!rd_rst_n) !rd_accept |=> ($stable(rd_ptr) && $stable(rd_data)));

  assert_read_advances_R5: assert property (@(posedge rd_clk)
    disable iff (!rd_rst_n) rd_accept |=> rd_ptr == $past(rd_ptr) + PTR_W'(1));

  assert_wr_wrap_R6: assert property (@(posedge wr_clk)
    disable iff (!wr_rst_n) (wr_fire && wr_ptr == LAST) |=> wr_ptr == '0);

  assert_rd_wrap_R6: assert property (@(posedge rd_clk)
    disable iff (!rd_rst_n) (rd_accept && rd_ptr == LAST) |=> rd_ptr == '0);

  assert_no_write_idle_R7: assert property (@(posedge wr_clk)
    disable iff (!wr_rst_n) !wr_en |=> $stable(wr_ptr));

  assert_ready_after_sync_R8: assert property (@(posedge rd_clk)
    disable iff (!rd_rst_n) $rose(ready) |-> $past(flag_synced));

  assert_sync_chain_R8: assert property (@(posedge rd_clk)
    disable iff (!rd_rst_n) $rose(flag_synced) |-> $past(flag_first));
endmodule

bind line_xfer_buf lxb_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .LINE_SAMPLES(LINE_SAMPLES),
  .READY_LINES(READY_LINES), .MARGIN_LINES(MARGIN_LINES), .THRESH(THRESH)
) u_lxb_checker (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_en(wr_en), .wr_fire(wr_fire), .wr_ptr(wr_ptr), .wr_count(wr_count),
  .wr_flag(wr_flag), .flag_first(flag_first), .flag_synced(flag_synced),
  .rd_accept(rd_accept), .rd_ptr(rd_ptr), .rd_data(rd_data), .ready(ready));

// File: tb/line_xfer_buf_bench.sv
`timescale 1ns/1ps
module line_xfer_buf_bench;
  localparam int DEPTH  = 1024;
  localparam int LINE   = 256;
  localparam int THRESH = 2 * LINE;   // two lines before ready
  localparam int GAP    = 40;         // blanking cycles between lines
  localparam int N_WR   = 3000;
  localparam int N_RD   = 2000;

  logic       rst_n = 1'b0;
  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ready;

  int  n_chk = 0, n_fail = 0;
  int  wr_done = 0;
  real t_wr_start = -1.0;

  line_xfer_buf u_line_xfer_buf (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .ready(ready));

  always #5 wr_clk = ~wr_clk;                       // 100 MHz
  initial begin #3; forever #5.2 rd_clk = ~rd_clk; end  // unrelated output clock

  task automatic chk(input bit ok, input string req,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writer();
    repeat (5) @(negedge wr_clk);
    t_wr_start = $realtime;
    for (int idx = 0; idx < N_WR; idx++) begin
      if (idx > 0 && idx % LINE == 0) begin   // R7: blanking, nothing stored
        wr_en = 1'b0;
        repeat (GAP) @(negedge wr_clk);
      end
      wr_en   = 1'b1;
      wr_data = 8'(idx);
      @(negedge wr_clk);
      wr_done++;
    end
    wr_en = 1'b0;
  endtask

  task automatic reader();
    int  got = 0, issued = 0;
    bit  pend = 1'b0, seen = 1'b0, r8_done = 1'b0;
    while (got < N_RD) begin
      @(negedge rd_clk);
      if (pend) begin
        if (got >= DEPTH)
          chk(rd_data == 8'(got), "R6 order after wrap", rd_data, got % 256);
        else
          chk(rd_data == 8'(got), "R5 order", rd_data, got % 256);
        got++;
      end else if (!seen && rd_en) begin
        chk(rd_data == 8'h00, "R4 request before ready ignored", rd_data, 0);
      end
      if (wr_done < THRESH)
        chk(ready == 1'b0, "R2 early ready", ready, 0);
      if (wr_done >= THRESH && !r8_done) begin
        chk(ready == 1'b0, "R8 ready crossed too fast", ready, 0);
        r8_done = 1'b1;
      end
      if (wr_done >= THRESH + 10)
        chk(ready == 1'b1, "R2 ready after two lines", ready, 1);
      if (seen)
        chk(ready == 1'b1, "R3 ready sticky", ready, 1);
      if (ready) seen = 1'b1;
      if (issued >= N_RD)
        rd_en = 1'b0;
      else if (t_wr_start >= 0.0 && $realtime >= t_wr_start + 4000.0)
        rd_en = 1'b1;
      pend = rd_en && ready;
      if (pend) issued++;
    end
    rd_en = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50;
    chk(ready == 1'b0, "R1 ready in reset", ready, 0);
    chk(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 0);
    #50;
    rst_n = 1'b1;
    fork
      writer();
      reader();
    join
    repeat (10) begin
      @(negedge rd_clk);
      chk(rd_data == 8'hCF, "R5 hold with no read", rd_data, 8'hCF);
      chk(ready == 1'b1, "R3 ready held", ready, 1);
    end
    rst_n = 1'b0;
    #2;
    chk(ready == 1'b0, "R3 cleared only by reset", ready, 0);
    chk(rd_data == 8'h00, "R1 rd_data cleared", rd_data, 0);
    #100;
    rst_n = 1'b1;
    repeat (50) begin
      @(negedge rd_clk);
      chk(ready == 1'b0, "R1 ready low after reset", ready, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule